// File: doc/BRIEF.md
# Serial ADC Readout Master with Echo Check

This block is the host-side controller for a three-wire serial analog-to-digital converter that returns one 12-bit sample per chip-select cycle. When a start request arrives, the controller drives chip-select low. It waits a programmable setup interval and then generates a data clock from the system clock, with high and low phases whose lengths are set by inputs. It samples the converter's data line at each rising data-clock edge and drops the positions the converter spends enabling its output and sending its null bit. It then shifts in the sample MSB first.

The converter replays the sample LSB first, starting from bit 1, when clocking continues. With echo checking enabled, the controller keeps clocking through that replay. It compares every replayed bit with the matching bit of the word it first received. When the transaction ends, chip-select returns high, which puts the converter into its shutdown state. The result then appears with a one-cycle valid strobe and a mismatch flag.

Top module: `adcrd_master`

## Requirements
- R1: After reset, cs_no is 1, sclk_o is 0, valid_o is 0 and mismatch_o is 0. The lines keep these values while no transaction runs.
- R2: A start_i seen at an idle clock edge drives cs_no low after that edge. The first rising edge of sclk_o follows max(setup_len_i,1) clocks later.
- R3: Each sclk_o high phase lasts max(hi_len_i,1) clocks. Each low phase between pulses lasts max(lo_len_i,1) clocks. sclk_o is high only while cs_no is low.
- R4: A transaction issues 15 sclk_o pulses with echo_en_i at 0 and 26 pulses with echo_en_i at 1. cs_no rises in the same clock that the last pulse falls.
- R5: sdo_i is sampled in the clock where sclk_o rises. The first three samples are discarded. Samples 4 to 15 form data_o, bit 11 first.
- R6: With echo checking on, samples 16 to 26 are compared with data_o bits 1, 2, ..., 11 in that order. mismatch_o is 1 if any of them differs.
- R7: mismatch_o is 0 whenever echo_en_i was 0 at the accepted start, and it is 0 in every cycle in which valid_o is 0.
- R8: valid_o is high for exactly one clock, in the clock where cs_no returns high. data_o holds its value until the next completion.
- R9: start_i is ignored while a transaction is in progress. The transaction's timing and result are unchanged.
- R10: echo_en_i is captured when a start is accepted. setup_len_i, hi_len_i and lo_len_i must be held stable while cs_no is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion readout |
| echo_en_i | input | 1 | Enable capture and compare of the LSB-first replay |
| setup_len_i | input | CNT_W | Clocks from chip-select low to the first rising clock edge |
| hi_len_i | input | CNT_W | Clocks per data-clock high phase |
| lo_len_i | input | CNT_W | Clocks per data-clock low phase |
| sdo_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Active-low chip-select |
| sclk_o | output | 1 | Data clock to the converter |
| data_o | output | DW | Received sample |
| valid_o | output | 1 | One-cycle completion strobe |
| mismatch_o | output | 1 | Replay disagreed with the sample; valid with valid_o |

## Verification
The bench uses the default parameters: a 12-bit word, three skipped leading positions, 8-bit phase counters and echo support compiled in. It drives the timing inputs with values of 0 and 1, so the minimum phase length of one clock and the clamping of a zero length are both exercised, and it also drives longer asymmetric phases. A converter model in the bench updates the data line on each falling clock edge, sends junk before the null bit and can flip any chosen replay bit. This exercises detection of single-bit echo errors, and confirms that a corrupted replay leaves the flag low when checking is off.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW
  } adcrd_st_e;
endpackage

// File: rtl/adcrd_timer.sv
module adcrd_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  // a length of zero behaves like one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  p_cnt_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/adcrd_capture.sv
module adcrd_capture #(
  parameter int DW           = 12,
  parameter int SKIP         = 3,
  parameter int EW           = 5,
  parameter bit ECHO_SUPPORT = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          rise_i,
  input  logic [EW-1:0] idx_i,
  input  logic          sdo_i,
  output logic [DW-1:0] word_o,
  output logic          mism_o
);
  localparam int FIRST = SKIP + 1;
  localparam int LASTW = SKIP + DW;
  localparam int ELAST = SKIP + 2 * DW - 1;
  localparam int BW    = $clog2(DW);

  logic [DW-1:0] word_q;
  logic          in_word;
  logic          in_echo;

  assign in_word = rise_i && (idx_i >= EW'(FIRST)) && (idx_i <= EW'(LASTW));
  assign in_echo = rise_i && (idx_i > EW'(LASTW)) && (idx_i <= EW'(ELAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       word_q <= '0;
    else if (clear_i)  word_q <= '0;
    else if (in_word)  word_q <= {word_q[DW-2:0], sdo_i};
  end

  assign word_o = word_q;

  generate
    if (ECHO_SUPPORT) begin : g_echo
      logic [BW-1:0] bsel;
      logic          mism_q;
      assign bsel = BW'(idx_i - EW'(LASTW));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              mism_q <= 1'b0;
        else if (clear_i)                         mism_q <= 1'b0;
        else if (in_echo && (sdo_i != word_q[bsel])) mism_q <= 1'b1;
      end
      assign mism_o = mism_q;
    end else begin : g_no_echo
      assign mism_o = 1'b0;
    end
  endgenerate

  p_word_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_echo && !clear_i) |=> $stable(word_q));
endmodule

// File: rtl/adcrd_master.sv
module adcrd_master
  import adcrd_pkg::*;
#(
  parameter int DW           = 12,
  parameter int SKIP         = 3,
  parameter int CNT_W        = 8,
  parameter bit ECHO_SUPPORT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             echo_en_i,
  input  logic [CNT_W-1:0] setup_len_i,
  input  logic [CNT_W-1:0] hi_len_i,
  input  logic [CNT_W-1:0] lo_len_i,
  input  logic             sdo_i,
  output logic             cs_no,
  output logic             sclk_o,
  output logic [DW-1:0]    data_o,
  output logic             valid_o,
  output logic             mismatch_o
);
  localparam int N_PLAIN = SKIP + DW;
  localparam int N_ECHO  = SKIP + 2 * DW - 1;
  localparam int EW      = $clog2(N_ECHO + 1);

  adcrd_st_e        st_q;
  logic [EW-1:0]    edge_q;
  logic [EW-1:0]    idx;
  logic [EW-1:0]    last_edge;
  logic             echo_q;
  logic             cs_q, sclk_q, valid_q, mism_q;
  logic [DW-1:0]    data_q;
  logic             tz, load, rise, done, clear;
  logic [CNT_W-1:0] len;
  logic [DW-1:0]    word;
  logic             mism;

  assign idx       = edge_q + 1'b1;
  assign last_edge = echo_q ? EW'(N_ECHO) : EW'(N_PLAIN);
  assign rise      = tz && (st_q == ST_SETUP || st_q == ST_LOW);
  assign done      = tz && (st_q == ST_HIGH) && (edge_q == last_edge);
  assign clear     = (st_q == ST_IDLE) && start_i;

  always_comb begin
    load = 1'b0;
    len  = hi_len_i;
    unique case (st_q)
      ST_IDLE:  if (start_i) begin load = 1'b1; len = setup_len_i; end
      ST_SETUP: if (tz) load = 1'b1;
      ST_HIGH:  if (tz && edge_q != last_edge) begin load = 1'b1; len = lo_len_i; end
      ST_LOW:   if (tz) load = 1'b1;
      default:  ;
    endcase
  end

  adcrd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .len_i  (len),
    .zero_o (tz)
  );

  adcrd_capture #(
    .DW(DW), .SKIP(SKIP), .EW(EW), .ECHO_SUPPORT(ECHO_SUPPORT)
  ) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .rise_i  (rise),
    .idx_i   (idx),
    .sdo_i   (sdo_i),
    .word_o  (word),
    .mism_o  (mism)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      edge_q <= '0;
      echo_q <= 1'b0;
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_SETUP;
          cs_q   <= 1'b0;
          edge_q <= '0;
          echo_q <= ECHO_SUPPORT ? echo_en_i : 1'b0;
        end
        ST_SETUP, ST_LOW: if (tz) begin
          st_q   <= ST_HIGH;
          sclk_q <= 1'b1;
          edge_q <= idx;
        end
        ST_HIGH: if (tz) begin
          sclk_q <= 1'b0;
          if (edge_q == last_edge) begin
            st_q <= ST_IDLE;
            cs_q <= 1'b1;
          end else begin
            st_q <= ST_LOW;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      mism_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= done;
      mism_q  <= done && echo_q && mism;
      if (done) data_q <= word;
    end
  end

  assign cs_no      = cs_q;
  assign sclk_o     = sclk_q;
  assign data_o     = data_q;
  assign valid_o    = valid_q;
  assign mismatch_o = mism_q;

  p_sclk_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);
  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_valid_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cs_no && !sclk_o));
  p_mism_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |-> (valid_o && echo_q));
  p_edges_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_q <= EW'(N_ECHO));
  p_busy_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && start_i) |=> $stable(echo_q));
  p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> (cs_no && !sclk_o));
endmodule

// File: tb/tb_adcrd_master.sv
module tb_adcrd_master;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       echo_en_i = 1'b0;
  logic [7:0] setup_len_i = 8'd1, hi_len_i = 8'd1, lo_len_i = 8'd1;
  logic       sdo_i = 1'b1;
  logic       cs_no, sclk_o, valid_o, mismatch_o;
  logic [11:0] data_o;

  int errors = 0, checks = 0;

  adcrd_master dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .echo_en_i(echo_en_i),
    .setup_len_i(setup_len_i), .hi_len_i(hi_len_i), .lo_len_i(lo_len_i),
    .sdo_i(sdo_i), .cs_no(cs_no), .sclk_o(sclk_o), .data_o(data_o),
    .valid_o(valid_o), .mismatch_o(mismatch_o)
  );

  always #2.5 clk_i = ~clk_i;

  // converter model state
  logic [11:0] dev_word = 12'h000;
  int          flip_bit = 0;   // replay bit to corrupt, 0 = none
  int          falls = 0, rises = 0;
  logic        prev_sclk = 1'b0;

  // reference model: {cs_n, sclk, valid} per clock after each edge
  logic [2:0] q[$];
  logic [2:0] exp_line = 3'b100;
  bit         model_echo = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q.delete();
      exp_line <= 3'b100;
    end else if (q.size() != 0) begin
      exp_line <= q.pop_front();
    end else if (start_i) begin
      int n, s, h, l;
      model_echo = echo_en_i;
      n = echo_en_i ? 26 : 15;
      s = (setup_len_i == 0) ? 1 : int'(setup_len_i);
      h = (hi_len_i == 0) ? 1 : int'(hi_len_i);
      l = (lo_len_i == 0) ? 1 : int'(lo_len_i);
      repeat (s) q.push_back(3'b000);
      for (int p = 1; p <= n; p++) begin
        repeat (h) q.push_back(3'b010);
        if (p < n) repeat (l) q.push_back(3'b000);
      end
      q.push_back(3'b101);
      exp_line <= q.pop_front();
    end else begin
      exp_line <= 3'b100;
    end
  end

  // converter: updates data after each falling data-clock edge
  always @(negedge clk_i) begin
    if (cs_no) begin
      falls = 0;
      rises = (valid_o) ? rises : 0;
      sdo_i = 1'b1;
    end else begin
      if (!prev_sclk && sclk_o) rises++;
      if (prev_sclk && !sclk_o) begin
        falls++;
        if (falls < 2)       sdo_i = 1'b1;
        else if (falls == 2) sdo_i = 1'b0;
        else if (falls <= 14) sdo_i = dev_word[14 - falls];
        else if (falls <= 25) sdo_i = dev_word[falls - 14] ^ (flip_bit == falls - 14);
        else                 sdo_i = 1'b0;
      end
    end
    prev_sclk = sclk_o;
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("R2 cs_no", cs_no, exp_line[2]);
      chk("R3 sclk_o", sclk_o, exp_line[1]);
      chk("R8 valid_o", valid_o, exp_line[0]);
      if (!valid_o) chk("R7 mismatch idle", mismatch_o, 0);
    end
  end

  task automatic run(input logic [11:0] w, input bit echo, input int flip,
                     input logic [7:0] su, input logic [7:0] hi, input logic [7:0] lo,
                     input bit poke_busy);
    dev_word = w; flip_bit = flip;
    @(negedge clk_i);
    echo_en_i = echo; setup_len_i = su; hi_len_i = hi; lo_len_i = lo;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    echo_en_i = ~echo;  // R10: captured at start only
    if (poke_busy) begin
      repeat (7) @(negedge clk_i);
      start_i = 1'b1;
      repeat (3) @(negedge clk_i);
      start_i = 1'b0;
    end
    while (!valid_o) @(negedge clk_i);
    chk("R5 data_o", data_o, w);
    chk(echo ? "R6 mismatch" : "R7 mismatch off", mismatch_o, (echo && flip != 0));
    chk("R4 pulse count", rises, echo ? 26 : 15);
    repeat (3) @(negedge clk_i);
    chk("R8 data held", data_o, w);
    chk("R9 idle after run", cs_no, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        chk("R1 cs_no reset", cs_no, 1);
        chk("R1 sclk_o reset", sclk_o, 0);
        chk("R1 valid_o reset", valid_o, 0);
        rst_ni = 1'b1;
        repeat (2) @(negedge clk_i);
        run(12'hA5C, 0, 0, 8'd4, 8'd2, 8'd3, 0);
        run(12'h3F1, 1, 0, 8'd0, 8'd1, 8'd1, 0);
        run(12'h801, 1, 1, 8'd2, 8'd1, 8'd2, 0);   // R6 flip bit 1
        run(12'h7FE, 1, 11, 8'd1, 8'd3, 8'd1, 0);  // R6 flip bit 11
        run(12'hC33, 0, 5, 8'd1, 8'd0, 8'd0, 0);   // R7 corrupt replay ignored
        run(12'h5A6, 0, 0, 8'd3, 8'd2, 8'd2, 1);   // R9 start while busy
        run(12'hFFF, 1, 6, 8'd1, 8'd1, 8'd1, 1);
        run(12'h000, 1, 0, 8'd5, 8'd2, 8'd1, 0);
      end
      begin
        repeat (100000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule